// File: doc/BRIEF.md
# Single-to-Half Precision Float Narrower

This block takes a 32-bit IEEE-754 binary32 operand and returns the nearest 16-bit binary16 value. Rounding is round-to-nearest with ties going to the even neighbour. The block handles every input class. Signed zeros and infinities map straight across. A NaN either keeps its sign and the top of its payload, with the quiet bit forced on, or becomes the canonical quiet NaN when the default-NaN control is set. Finite values are rounded into the half-precision normal range, rounded into the subnormal range, or saturate to a signed infinity on overflow. Flush-to-zero is never applied.

The conversion is combinational. One register stage sits at the output, so a result and its four exception flags appear one clock after the operand is presented. The flags are invalid operation, overflow, underflow and inexact. A new operand can be accepted every cycle.

Top module: `half_narrower`

## Requirements
- R1: While reset is asserted, `result` and all four flags read 0. Otherwise the outputs on the cycle after a rising edge reflect the `operand` and `dnan_mode` sampled at that edge.
- R2: An operand with exponent field 0 and mantissa 0 gives `{sign,15'h0000}`. An operand with exponent field 0xFF and mantissa 0 gives `{sign,15'h7C00}`. Neither raises any flag.
- R3: A NaN operand (exponent field 0xFF, mantissa nonzero) with `dnan_mode`=0 gives `{sign, 5'b11111, m[22:13]}` with bit 9 forced to 1, where m is the operand mantissa.
- R4: A NaN operand with `dnan_mode`=1 gives 16'h7E00 regardless of sign and payload.
- R5: `flag_invalid` is 1 exactly when the operand is a signalling NaN: exponent field 0xFF, bit 22 clear, mantissa nonzero. A quiet NaN raises no flag.
- R6: A finite operand whose half result is a normal number is rounded to 11 significant bits, nearest first, and on a tie to the neighbour with an even last bit.
- R7: A finite operand whose rounded magnitude is 65536 or more gives `{sign,15'h7C00}` with `flag_overflow` and `flag_inexact` set. 65504 itself stays finite (0x7BFF). 65520 ties upward and overflows.
- R8: A finite operand below 2^-14 in magnitude is rounded to a multiple of 2^-24 and encoded with exponent field 0. A value that rounds to zero keeps its sign. This includes every binary32 subnormal.
- R9: When rounding carries out of the significand, the exponent field increments. The largest subnormal plus a tie (2047×2^-25) becomes 0x0400, and 2047.5 ties upward to 2048 (0x6800).
- R10: `flag_inexact` is 1 when any discarded bit of a finite operand is nonzero. `flag_underflow` is 1 when the operand's magnitude is below 2^-14 before rounding and the result is inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand | input | 32 | binary32 value to narrow |
| dnan_mode | input | 1 | 1: every NaN becomes 0x7E00 |
| result | output | 16 | binary16 result, registered |
| flag_invalid | output | 1 | Signalling NaN seen |
| flag_overflow | output | 1 | Result saturated to infinity |
| flag_underflow | output | 1 | Tiny and inexact |
| flag_inexact | output | 1 | Result differs from the operand |

## Verification
The bench concentrates on the rounding boundaries:
- Exact ties in both the normal and subnormal ranges. A design that rounds ties away from zero returns an odd last bit there.
- The 65504/65520 edge. A design that checks overflow before rounding leaves 65520 finite.
- 2^-25 and just above it. A wrong sticky bit turns the zero into 0x0001 or the reverse.
- The largest-subnormal carry into 0x0400.
- NaN payload truncation with and without default-NaN mode, and signalling versus quiet NaNs. A design that forgets the quiet bit emits an infinity or a signalling pattern.

Binary32 subnormal inputs are also driven, to check that the sign survives and that underflow is raised. A run of seeded random operands, biased toward the half-precision exponent range, is compared against an integer-scaled model that rounds a multiple of 2^-24 rather than shifting a significand.

// File: rtl/narrow_pkg.sv
package narrow_pkg;
    localparam int SRC_W      = 32;
    localparam int SRC_EXP_W  = 8;
    localparam int SRC_MAN_W  = 23;
    localparam int DST_W      = 16;
    localparam int DST_EXP_W  = 5;
    localparam int DST_MAN_W  = 10;
    localparam int SRC_BIAS   = (1 << (SRC_EXP_W - 1)) - 1;
    localparam int DST_BIAS   = (1 << (DST_EXP_W - 1)) - 1;
    localparam int MAN_DROP   = SRC_MAN_W - DST_MAN_W;
    localparam int SIG_W      = SRC_MAN_W + 1;
    localparam int DST_EMIN   = 1 - DST_BIAS;
    localparam int SHIFT_CAP  = MAN_DROP * 2;

    localparam logic [DST_W-2:0] DST_INF_MAG = {{DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};
    localparam logic [DST_W-1:0] DST_QNAN    = {1'b0, {DST_EXP_W{1'b1}}, 1'b1, {(DST_MAN_W-1){1'b0}}};

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN,
        CLS_FINITE
    } src_class_e;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic inexact;
    } flags_t;

    typedef struct packed {
        logic [DST_W-1:0] bits;
        flags_t           flags;
    } outcome_t;
endpackage

// File: rtl/narrow_unpack.sv
module narrow_unpack
    import narrow_pkg::*;
(
    input  logic [SRC_W-1:0]     word_i,
    output logic                 sign_o,
    output logic [SRC_EXP_W-1:0] exp_o,
    output logic [SRC_MAN_W-1:0] man_o,
    output src_class_e           cls_o
);
    logic exp_ones;
    logic exp_zero;
    logic man_zero;

    always_comb begin
        sign_o   = word_i[SRC_W-1];
        exp_o    = word_i[SRC_W-2 -: SRC_EXP_W];
        man_o    = word_i[SRC_MAN_W-1:0];
        exp_ones = &exp_o;
        exp_zero = ~|exp_o;
        man_zero = ~|man_o;
        if (exp_ones) begin
            if (man_zero)                 cls_o = CLS_INF;
            else if (man_o[SRC_MAN_W-1])  cls_o = CLS_QNAN;
            else                          cls_o = CLS_SNAN;
        end else if (exp_zero && man_zero) begin
            cls_o = CLS_ZERO;
        end else begin
            cls_o = CLS_FINITE;
        end
    end
endmodule

// File: rtl/narrow_nan.sv
module narrow_nan
    import narrow_pkg::*;
(
    input  logic                 sign_i,
    input  logic [SRC_MAN_W-1:0] man_i,
    input  logic                 signalling_i,
    input  logic                 dnan_i,
    output outcome_t             out_o
);
    logic [DST_W-1:0] carried;

    always_comb begin
        carried = {sign_i, DST_INF_MAG} | {{(DST_W-DST_MAN_W){1'b0}}, man_i[SRC_MAN_W-1 -: DST_MAN_W]};
        carried[DST_MAN_W-1] = 1'b1;
        out_o.bits            = dnan_i ? DST_QNAN : carried;
        out_o.flags.invalid   = signalling_i;
        out_o.flags.overflow  = 1'b0;
        out_o.flags.underflow = 1'b0;
        out_o.flags.inexact   = 1'b0;
    end
endmodule

// File: rtl/narrow_round.sv
module narrow_round
    import narrow_pkg::*;
(
    input  logic                 sign_i,
    input  logic [SRC_EXP_W-1:0] exp_i,
    input  logic [SRC_MAN_W-1:0] man_i,
    output outcome_t             out_o
);
    localparam int EW  = SRC_EXP_W + 2;
    localparam int SHW = $clog2(SHIFT_CAP + 1);
    localparam int WW  = 32;
    localparam int KW  = DST_MAN_W + 2;
    localparam int SW  = DST_W + 1;

    logic signed [EW-1:0]  unb;
    logic signed [EW-1:0]  extra;
    logic [SIG_W-1:0]      sig;
    logic [WW-1:0]         wide;
    logic [SHW-1:0]        sh;
    logic                  tiny;
    logic                  big;
    logic [KW-1:0]         kept;
    logic                  guard_b;
    logic                  sticky_b;
    logic                  bump;
    logic [KW-1:0]         rnd;
    logic [DST_EXP_W-1:0]  bexp;
    logic [SW-1:0]         sum;
    logic                  ovf;

    always_comb begin
        sig = {|exp_i, man_i};
        if (exp_i == '0) unb = EW'(1 - SRC_BIAS);
        else             unb = $signed({2'b00, exp_i}) - EW'(SRC_BIAS);
        tiny  = unb < EW'(DST_EMIN);
        big   = unb > EW'(DST_BIAS);
        extra = EW'(DST_EMIN) - unb;

        if (!tiny)                           sh = SHW'(MAN_DROP);
        else if (extra > EW'(MAN_DROP))      sh = SHW'(SHIFT_CAP);
        else                                 sh = SHW'(MAN_DROP) + SHW'(extra);

        wide     = WW'(sig);
        kept     = KW'(wide >> sh);
        guard_b  = wide[sh - SHW'(1)];
        sticky_b = |(wide & ((WW'(1) << (sh - SHW'(1))) - WW'(1)));
        bump     = guard_b & (sticky_b | kept[0]);
        rnd      = kept + KW'(bump);

        bexp = DST_EXP_W'(unb + EW'(DST_BIAS - 1));
        if (tiny) sum = SW'(rnd);
        else      sum = {2'b00, bexp, {DST_MAN_W{1'b0}}} + SW'(rnd);

        ovf = big || (sum >= SW'(DST_INF_MAG));

        out_o.bits            = ovf ? {sign_i, DST_INF_MAG} : {sign_i, sum[DST_W-2:0]};
        out_o.flags.invalid   = 1'b0;
        out_o.flags.overflow  = ovf;
        out_o.flags.inexact   = guard_b | sticky_b | ovf;
        out_o.flags.underflow = tiny & (guard_b | sticky_b);
    end
endmodule

// File: rtl/half_narrower.sv
module half_narrower
    import narrow_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_W-1:0]     operand,
    input  logic                 dnan_mode,
    output logic [DST_W-1:0]     result,
    output logic                 flag_invalid,
    output logic                 flag_overflow,
    output logic                 flag_underflow,
    output logic                 flag_inexact
);
    logic                 in_sign;
    logic [SRC_EXP_W-1:0] in_exp;
    logic [SRC_MAN_W-1:0] in_man;
    src_class_e           in_cls;
    outcome_t             nan_out;
    outcome_t             fin_out;
    outcome_t             res_d;
    outcome_t             res_q;

    narrow_unpack u_unpack (
        .word_i (operand),
        .sign_o (in_sign),
        .exp_o  (in_exp),
        .man_o  (in_man),
        .cls_o  (in_cls)
    );

    narrow_nan u_nan (
        .sign_i       (in_sign),
        .man_i        (in_man),
        .signalling_i (in_cls == CLS_SNAN),
        .dnan_i       (dnan_mode),
        .out_o        (nan_out)
    );

    narrow_round u_round (
        .sign_i (in_sign),
        .exp_i  (in_exp),
        .man_i  (in_man),
        .out_o  (fin_out)
    );

    always_comb begin
        res_d = '0;
        unique case (in_cls)
            CLS_ZERO:           res_d.bits = {in_sign, {(DST_W-1){1'b0}}};
            CLS_INF:            res_d.bits = {in_sign, DST_INF_MAG};
            CLS_QNAN, CLS_SNAN: res_d = nan_out;
            default:            res_d = fin_out;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign result         = res_q.bits;
    assign flag_invalid   = res_q.flags.invalid;
    assign flag_overflow  = res_q.flags.overflow;
    assign flag_underflow = res_q.flags.underflow;
    assign flag_inexact   = res_q.flags.inexact;

    // R2: signed zero passes through with no flag
    p_zero_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (operand[SRC_W-2:0] == '0) |=> (result == {$past(operand[SRC_W-1]), 15'h0000}) && !flag_inexact);

    // R4: default-NaN mode yields the canonical quiet NaN
    p_default_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dnan_mode && (&operand[30:23]) && (operand[22:0] != '0)) |=> (result == 16'h7E00));

    // R5: a signalling NaN operand raises invalid on the next cycle
    p_snan_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((operand[30:22] == 9'h1FE) && (operand[21:0] != '0)) |=> flag_invalid);

    // R5: invalid only ever accompanies a quiet NaN result
    p_invalid_is_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |-> (result[14:9] == 6'h3F));

    // R7: overflow always saturates and is inexact
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow |-> (result[14:0] == 15'h7C00) && flag_inexact);

    // R10: underflow implies inexact and a subnormal-or-min-normal result
    p_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_underflow |-> flag_inexact && (result[14:10] <= 5'd1));
endmodule

// File: tb/half_narrower_test.sv
`timescale 1ns/1ps
module half_narrower_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand = 32'h0;
    logic        dnan_mode = 1'b0;
    logic [15:0] result;
    logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    half_narrower uut (
        .clk(clk), .rst_n(rst_n), .operand(operand), .dnan_mode(dnan_mode),
        .result(result), .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
        .flag_underflow(flag_underflow), .flag_inexact(flag_inexact)
    );

    // Model: scale to units of 2^-24, round to the local ulp, re-encode.
    // Returns {invalid, overflow, underflow, inexact, bits[15:0]}.
    function automatic logic [19:0] model(input logic [31:0] op, input logic dn);
        logic        s;
        int          e, ex, lsh, ush, dsh, p, j;
        logic [22:0] m;
        logic [63:0] n, q, rem, halfv, v;
        logic [15:0] r;
        s = op[31]; e = int'(op[30:23]); m = op[22:0];
        if (e == 255) begin
            if (m == 0) return {4'b0000, s, 15'h7C00};
            if (dn) r = 16'h7E00;
            else    r = {s, 5'h1F, 1'b1, m[21:13]};
            return {!m[22], 3'b000, r};
        end
        if (e == 0 && m == 0) return {4'b0000, s, 15'h0};
        ex = (e == 0) ? -126 : e - 127;
        if (ex > 15) return {4'b0101, s, 15'h7C00};
        lsh = (ex + 1 > 0) ? ex + 1 : 0;
        ush = (ex + 14 > 0) ? ex + 14 : 0;
        dsh = (-(ex + 1) > 0) ? -(ex + 1) : 0;
        p = ush + dsh;
        if (p > 60) p = 60;
        n = {40'd0, (e != 0), m} << lsh;
        q = n >> p;
        rem = n - (q << p);
        halfv = 64'd1 << (p - 1);
        if (rem > halfv || (rem == halfv && q[0])) q = q + 1;
        v = q << ush;
        if (v >= (64'd1 << 40)) return {4'b0101, s, 15'h7C00};
        if (v < 1024) r = {s, v[14:0]};
        else begin
            j = 0;
            for (int b = 0; b < 41; b++) if (v[b]) j = b;
            v = (v >> (j - 10)) - 64'd1024;
            r = {s, 5'(j - 9), v[9:0]};
        end
        return {1'b0, 1'b0, (ex < -14) && (rem != 0), rem != 0, r};
    endfunction

    task automatic check(input logic [31:0] op, input logic dn, input string tag);
        logic [19:0] exp_v, got;
        @(negedge clk);
        operand = op; dnan_mode = dn;
        @(negedge clk);
        exp_v = model(op, dn);
        got = {flag_invalid, flag_overflow, flag_underflow, flag_inexact, result};
        tests++;
        if (got !== exp_v) begin
            fails++;
            $display("FAIL %s op=%h dn=%0b got=%h expected=%h", tag, op, dn, got, exp_v);
        end
    endtask

    task automatic check_lit(input logic [31:0] op, input logic dn, input logic [19:0] want, input string tag);
        logic [19:0] got;
        @(negedge clk);
        operand = op; dnan_mode = dn;
        @(negedge clk);
        got = {flag_invalid, flag_overflow, flag_underflow, flag_inexact, result};
        tests++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s op=%h got=%h expected=%h", tag, op, got, want);
        end
    endtask

    function automatic string tag_of(input logic [31:0] op);
        int e;
        e = int'(op[30:23]);
        if (e == 255) return "R3";
        if (e > 142) return "R7";
        if (e < 113) return "R8";
        return "R6";
    endfunction

    initial begin
        #800000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240407));
        operand = 32'h3F80_0000;
        repeat (3) @(negedge clk);
        tests++;
        if ({flag_invalid, flag_overflow, flag_underflow, flag_inexact, result} !== 20'h0) begin
            fails++;
            $display("FAIL R1 reset got=%h expected=0", result);
        end
        rst_n = 1'b1;

        check_lit(32'h0000_0000, 0, 20'h0_0000, "R2 +zero");
        check_lit(32'h8000_0000, 0, 20'h0_8000, "R2 -zero");
        check_lit(32'h7F80_0000, 0, 20'h0_7C00, "R2 +inf");
        check_lit(32'hFF80_0000, 0, 20'h0_FC00, "R2 -inf");
        check_lit(32'h7FC0_2000, 0, 20'h0_7E01, "R3 qnan payload");
        check_lit(32'hFF80_4000, 0, 20'h8_FE02, "R3 R5 snan payload");
        check_lit(32'h7F80_0001, 0, 20'h8_7E00, "R5 snan low payload");
        check_lit(32'hFFC0_0000, 1, 20'h0_7E00, "R4 dn qnan");
        check_lit(32'hFF80_0001, 1, 20'h8_7E00, "R4 dn snan");
        check_lit(32'h3F80_0000, 0, 20'h0_3C00, "R6 one");
        check_lit(32'h3F80_1000, 0, 20'h1_3C00, "R6 tie to even down");
        check_lit(32'h3F80_3000, 0, 20'h1_3C02, "R6 tie to even up");
        check_lit(32'h477F_E000, 0, 20'h0_7BFF, "R7 max finite");
        check_lit(32'h477F_F000, 0, 20'h5_7C00, "R7 tie overflow");
        check_lit(32'hC77F_F000, 0, 20'h5_FC00, "R7 neg overflow");
        check_lit(32'h3380_0000, 0, 20'h0_0001, "R8 min subnormal");
        check_lit(32'h3300_0000, 0, 20'h3_0000, "R8 half min tie to zero");
        check_lit(32'hB300_0001, 0, 20'h3_8001, "R8 above half min");
        check_lit(32'h8000_0001, 0, 20'h3_8000, "R8 single subnormal keeps sign");
        check_lit(32'h387F_F000, 0, 20'h3_0400, "R9 subnormal to min normal");
        check_lit(32'h44FF_F000, 0, 20'h1_6800, "R9 carry into exponent");
        check_lit(32'h3880_0000, 0, 20'h0_0400, "R10 exact min normal no underflow");
        check_lit(32'h3E2A_AAAB, 0, 20'h1_3155, "R10 inexact normal");

        for (int i = 0; i < 4000; i++) begin
            r = $urandom;
            if (i % 4 != 0) r[30:23] = 8'(100 + ($urandom % 48));
            check(r, 1'(($urandom % 8) == 0), tag_of(r));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule